// File: doc/BRIEF.md
# Interrupt Group Register Block

This block holds the registers for one group of up to 31 interrupt sources. Each source has a status bit that captures a rising edge on its input. Each source also has an enable bit, and software changes an enable bit only through two write-one registers: one sets it and one clears it. Both of those registers read back the live enable vector. A read-only result register shows status gated by enable. Its top bit always reads as one. The enabled results are ORed into one registered group interrupt. A control register holds a vector address field that the surrounding interrupt logic reads.

Software reaches the block through a simple 32-bit word port. A write takes effect at the next clock edge, and read data is combinational from the address. The parameter `VALID_MASK` says which source positions are assigned. Unassigned positions never hold state and read as zero in every register.

Top module: `irq_group_regs`

## Requirements
- R1: After reset the status, enable and vector fields are zero, the result register reads 0x8000_0000, and `group_irq` is 0.
- R2: Writing to word 1 (enable-set) sets every enable bit whose data bit is one. Zero bits have no effect. Words 1 and 2 both read the enable vector in bits 30:0, with bit 31 as 0.
- R3: Writing to word 2 (enable-clear) clears every enable bit whose data bit is one. Zero bits have no effect.
- R4: A status bit in word 0 is set one cycle after a low-to-high change of its source input. A source that stays high does not set the bit again once it has been cleared.
- R5: Writing a one to a status bit in word 0 clears it, and a zero has no effect. A rising source edge in the same cycle as the clear leaves the bit set.
- R6: Word 3 (result) reads status AND enable in bits 30:0, with bit 31 always 1. Writes to it are ignored.
- R7: `group_irq` equals the OR of result bits 30:0, delayed by one clock. The constant bit 31 is not included.
- R8: Word 4 (control) stores data bits 17:1 as the vector address. Its other bits read 0.
- R9: Positions cleared in `VALID_MASK` ignore writes and source events, and read 0 in words 0 to 3.
- R10: Words 5 to 7, and any address with bits above bit 2 set, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| src_evt | input | 31 | Source event inputs, one per position |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| group_irq | output | 1 | Registered OR of the enabled, pending sources |

## Verification
The assertions assume a single bus port, so only one register is written in any cycle. They also assume that source inputs and bus signals are synchronous to `clk` and are stable around the clock edge. The bench meets these assumptions by changing every input on the falling edge. It issues exactly one access per cycle, and it makes the clear-versus-event collision happen by raising a source in the same cycle as a status write. Reset is applied while all sources are held low.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
   localparam int NSRC = 31;

   localparam logic [2:0] REG_STAT   = 3'd0;
   localparam logic [2:0] REG_ENSET  = 3'd1;
   localparam logic [2:0] REG_ENCLR  = 3'd2;
   localparam logic [2:0] REG_RESULT = 3'd3;
   localparam logic [2:0] REG_CTRL   = 3'd4;

   typedef struct packed {
      logic stat;
      logic en_set;
      logic en_clr;
      logic ctrl;
   } wr_strobe_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_grp_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   output logic              hit,
   output logic [2:0]        sel,
   output wr_strobe_t        wstb
);
   logic upper_zero;

   generate
      if (ADDR_W > 3) begin : g_wide
         assign upper_zero = ~|bus_addr[ADDR_W-1:3];
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign sel = bus_addr[2:0];
   assign hit = upper_zero;

   always_comb begin
      wstb        = '0;
      wstb.stat   = bus_we && hit && (sel == REG_STAT);
      wstb.en_set = bus_we && hit && (sel == REG_ENSET);
      wstb.en_clr = bus_we && hit && (sel == REG_ENCLR);
      wstb.ctrl   = bus_we && hit && (sel == REG_CTRL);
   end
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter int              N     = 31,
   parameter logic [N-1:0]    VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_evt,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   output logic [N-1:0] rise,
   output logic [N-1:0] status
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic prev_q;
         logic stat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               stat_q <= 1'b0;
            end else begin
               prev_q <= src_evt[i];
               if (src_evt[i] && !prev_q)
                  stat_q <= 1'b1;
               else if (clr_we && clr_bits[i])
                  stat_q <= 1'b0;
            end
         end
         assign rise[i]   = src_evt[i] & ~prev_q;
         assign status[i] = stat_q;
      end else begin : g_tied
         assign rise[i]   = 1'b0;
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int              N     = 31,
   parameter logic [N-1:0]    VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] bits,
   output logic [N-1:0] enable
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic en_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               en_q <= 1'b0;
            else if (clr_we && bits[i])
               en_q <= 1'b0;
            else if (set_we && bits[i])
               en_q <= 1'b1;
         end
         assign enable[i] = en_q;
      end else begin : g_tied
         assign enable[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_group_regs.sv
module irq_group_regs
   import irq_grp_pkg::*;
#(
   parameter logic [30:0] VALID_MASK = 31'h7FF0_FFFF,
   parameter int          ADDR_W     = 3,
   parameter int          VEC_LO     = 1,
   parameter int          VEC_HI     = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [30:0]       src_evt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              group_irq
);
   localparam int VEC_W = VEC_HI - VEC_LO + 1;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("irq_group_regs: ADDR_W must be at least 3");
      end
      if (VEC_LO < 0 || VEC_HI > 31 || VEC_HI < VEC_LO) begin : g_bad_vec
         $error("irq_group_regs: vector field out of range");
      end
   endgenerate

   logic             hit;
   logic [2:0]       sel;
   wr_strobe_t       wstb;
   logic [NSRC-1:0]  stat_q;
   logic [NSRC-1:0]  en_q;
   logic [NSRC-1:0]  rise_w;
   logic [NSRC-1:0]  res_w;
   logic [VEC_W-1:0] vec_q;
   logic             grp_q;

   irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .hit      (hit),
      .sel      (sel),
      .wstb     (wstb)
   );

   irq_src_latch #(.N(NSRC), .VALID(VALID_MASK)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_evt  (src_evt),
      .clr_we   (wstb.stat),
      .clr_bits (bus_wdata[NSRC-1:0]),
      .rise     (rise_w),
      .status   (stat_q)
   );

   irq_enable_reg #(.N(NSRC), .VALID(VALID_MASK)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wstb.en_set),
      .clr_we (wstb.en_clr),
      .bits   (bus_wdata[NSRC-1:0]),
      .enable (en_q)
   );

   assign res_w = stat_q & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= '0;
         grp_q <= 1'b0;
      end else begin
         if (wstb.ctrl)
            vec_q <= bus_wdata[VEC_HI:VEC_LO];
         grp_q <= |res_w;
      end
   end

   assign group_irq = grp_q;

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sel)
            REG_STAT:   bus_rdata = {1'b0, stat_q};
            REG_ENSET:  bus_rdata = {1'b0, en_q};
            REG_ENCLR:  bus_rdata = {1'b0, en_q};
            REG_RESULT: bus_rdata = {1'b1, res_w};
            REG_CTRL:   bus_rdata[VEC_HI:VEC_LO] = vec_q;
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_group_regs_chk.sv
module irq_group_regs_chk #(
   parameter logic [30:0] VALID_MASK = '1,
   parameter int          ADDR_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              group_irq,
   input logic [30:0]       en,
   input logic [30:0]       stat,
   input logic [30:0]       res,
   input logic [30:0]       rise
);
   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1)) |=>
         (($past(bus_wdata[30:0]) & VALID_MASK) & ~en) == '0);

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(2)) |=> (en & $past(bus_wdata[30:0])) == '0);

   // R5
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($past(rise) & ~stat) == '0);

   // R6
   res_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3)) |-> (bus_rdata == {1'b1, res}));

   // R7
   grp_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (group_irq == |$past(res)));

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en | stat) & ~VALID_MASK) == '0);
endmodule

bind irq_group_regs irq_group_regs_chk #(.VALID_MASK(VALID_MASK), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .group_irq (group_irq),
   .en        (en_q),
   .stat      (stat_q),
   .res       (res_w),
   .rise      (rise_w)
);

// File: tb/irq_group_regs_bench.sv
module irq_group_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [30:0] src_evt = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        group_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   irq_group_regs u_irq_group_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_evt   (src_evt),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .group_irq (group_irq)
   );

   // {rd, addr[2:0], data[31:0], exp[31:0], req[3:0]}; valid mask is 0x7FF0_FFFF
   localparam int NV = 21;
   localparam logic [71:0] VEC [0:NV-1] = '{
      {1'b0, 3'd1, 32'h0000_00FF, 32'h0,         4'd2},  // R2
      {1'b1, 3'd1, 32'h0,         32'h0000_00FF, 4'd2},  // R2
      {1'b1, 3'd2, 32'h0,         32'h0000_00FF, 4'd2},  // R2
      {1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0,         4'd2},  // R2
      {1'b1, 3'd1, 32'h0,         32'h7FF0_FFFF, 4'd9},  // R9
      {1'b0, 3'd2, 32'h0000_000F, 32'h0,         4'd3},  // R3
      {1'b1, 3'd2, 32'h0,         32'h7FF0_FFF0, 4'd3},  // R3
      {1'b0, 3'd2, 32'h0,         32'h0,         4'd3},  // R3
      {1'b1, 3'd1, 32'h0,         32'h7FF0_FFF0, 4'd3},  // R3
      {1'b0, 3'd4, 32'hFFFF_FFFF, 32'h0,         4'd8},  // R8
      {1'b1, 3'd4, 32'h0,         32'h0003_FFFE, 4'd8},  // R8
      {1'b0, 3'd4, 32'h0000_1235, 32'h0,         4'd8},  // R8
      {1'b1, 3'd4, 32'h0,         32'h0000_1234, 4'd8},  // R8
      {1'b0, 3'd6, 32'hFFFF_FFFF, 32'h0,         4'd10}, // R10
      {1'b1, 3'd6, 32'h0,         32'h0,         4'd10}, // R10
      {1'b1, 3'd1, 32'h0,         32'h7FF0_FFF0, 4'd10}, // R10
      {1'b1, 3'd5, 32'h0,         32'h0,         4'd10}, // R10
      {1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0,         4'd6},  // R6
      {1'b1, 3'd3, 32'h0,         32'h8000_0000, 4'd6},  // R6
      {1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0,         4'd5},  // R5
      {1'b1, 3'd0, 32'h0,         32'h0,         4'd5}   // R5
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input int req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_chk(3'd0, 32'h0, 1);
      rd_chk(3'd1, 32'h0, 1);
      rd_chk(3'd3, 32'h8000_0000, 1);
      rd_chk(3'd4, 32'h0, 1);
      check(1, {31'h0, group_irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][71])
            rd_chk(VEC[i][70:68], VEC[i][35:4], int'(VEC[i][3:0]));
         else
            wr(VEC[i][70:68], VEC[i][67:36]);
      end

      // R4 edge capture on source 4; R7 one-cycle delay
      @(negedge clk);
      src_evt[4] = 1'b1;
      @(negedge clk);
      rd_chk(3'd0, 32'h0000_0010, 4);
      rd_chk(3'd3, 32'h8000_0010, 6);
      check(7, {31'h0, group_irq}, 32'h0);
      @(negedge clk);
      check(7, {31'h0, group_irq}, 32'h1);

      // R5 clear while source is held high; R4 no re-capture
      wr(3'd0, 32'h0000_0010);
      rd_chk(3'd0, 32'h0, 4);
      @(negedge clk);
      check(7, {31'h0, group_irq}, 32'h0);

      // R9 masked source 17 not captured
      src_evt[17] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd_chk(3'd0, 32'h0, 9);
      check(9, {31'h0, group_irq}, 32'h0);

      // R5 rising event in the same cycle as its clear
      @(negedge clk);
      src_evt[5] = 1'b1;
      bus_addr   = 3'd0;
      bus_wdata  = 32'h0000_0020;
      bus_we     = 1'b1;
      @(negedge clk);
      bus_we     = 1'b0;
      bus_wdata  = '0;
      rd_chk(3'd0, 32'h0000_0020, 5);

      // R5 zero write leaves status alone
      wr(3'd0, 32'h0);
      rd_chk(3'd0, 32'h0000_0020, 5);
      check(7, {31'h0, group_irq}, 32'h1);

      // R3 clearing enable drops result and group output
      wr(3'd2, 32'h0000_0020);
      rd_chk(3'd3, 32'h8000_0000, 3);
      @(negedge clk);
      check(7, {31'h0, group_irq}, 32'h0);

      // R1 reset mid-run
      src_evt = '0;
      rst_n   = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(3'd0, 32'h0, 1);
      rd_chk(3'd2, 32'h0, 1);
      rd_chk(3'd3, 32'h8000_0000, 1);
      rd_chk(3'd4, 32'h0, 1);
      check(1, {31'h0, group_irq}, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule